// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit-only master side of an I2C controller. It drives the SCL and SDA lines as open-drain pull-downs, with SCL timing set by a small divider. A host writes control fields to request start and stop conditions. It also writes bytes into a holding register. A shift register behind that holding register sends the bytes out, most significant bit first, and each byte is followed by an acknowledge clock. The host is expected to put the slave address and direction bit into the first byte after a start, with direction 0 meaning the master writes to the slave.

Status outputs show whether the holding register can take another byte, whether the last queued byte has finished, the acknowledge level sampled on the ninth clock, a sticky NACK indication, whether the bus is owned, and whether a stop has completed. When a byte finishes and nothing is queued, SCL is held low until the host writes data or asks for a stop. Only then does the bus move on.

Top module: `i2c_master_tx`

## Requirements
- R1: A start is accepted only when the host writes busy=1 with the start/stop control bit 0, while the master and transmit mode inputs are both 1 and `bus_busy` is 0. Any other control write leaves the bus idle. An accepted start sets `bus_busy`, clears `stop_seen`, and pulls SDA low while SCL is released.
- R2: Each byte is sent most significant bit first, one bit per SCL pulse, and a ninth pulse follows for the acknowledge. SDA changes only while SCL is low, except during start and stop.
- R3: With divider select S, every SCL high phase and every SCL low phase inside a byte lasts 2*(S+1) clock cycles.
- R4: `tx_empty` is 1 after reset. An accepted data write clears it, and it is set again when the byte moves into the shift register. A data write while `tx_empty` is 0 is ignored.
- R5: If no byte is queued, `tx_end` is set in the same cycle that SCL is released for the ninth (acknowledge) pulse. An accepted data write or a stop request clears it.
- R6: The SDA level sampled during the ninth pulse is shown on `ack_rcvd`, where 1 means the slave did not acknowledge.
- R7: When `nack_det_en` is 1, a sampled NACK sets `nack_flag`, which stays set until a stop request clears it. When `nack_det_en` is 0, a NACK does not set it.
- R8: Between bytes with nothing to send, and after a start before any data, the block pulls SCL low and releases SDA until data or a stop request arrives.
- R9: A stop request (busy=0 with control bit 0) is carried out at the next byte boundary: SDA is released while SCL is high. Afterwards `stop_seen` is 1, `bus_busy` is 0, and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 4 | SCL divider select; each quarter SCL period is div_sel+1 cycles |
| mode_master | input | 1 | Master mode select |
| mode_xmit | input | 1 | Transmit direction select |
| nack_det_en | input | 1 | Enables setting of nack_flag |
| ctl_wr | input | 1 | Control write strobe |
| ctl_busy_wd | input | 1 | Busy field of the control write (1 start, 0 stop) |
| ctl_ss_wd | input | 1 | Start/stop control field; must be 0 for a request |
| dat_wr | input | 1 | Holding register write strobe |
| dat_wd | input | 8 | Byte to transmit |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_end | output | 1 | Last queued byte finished |
| ack_rcvd | output | 1 | Sampled acknowledge bit (1 = NACK) |
| nack_flag | output | 1 | Sticky NACK indication |
| bus_busy | output | 1 | Bus owned by this master |
| stop_seen | output | 1 | Stop condition completed |

## Verification
The assertions check several properties on every cycle. A transfer-end flag may rise only together with an SCL release. A NACK flag may rise only with a sampled NACK and with detection enabled. SDA must hold steady while SCL stays released inside a byte. The bus must be idle whenever it is not owned or a stop has completed. The holding register may hand over a byte only when it holds one. The bench scenarios decode the lines as a slave would, with ACK or NACK answers, and show the rest. They check byte contents and bit order, the SCL phase lengths for several divider settings, that a write to a full holding register has no effect, the clock stretch between bytes, and the clearing of the flags by data writes and stop requests.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  // Engine states: bus idle, start sequence, byte boundary, bit clocking, stop sequence
  typedef enum logic [3:0] {
    S_IDLE,
    S_SU,
    S_STA,
    S_STA_LO,
    S_HOLD,
    S_BIT,
    S_STO_LO,
    S_STO_HI,
    S_STO_REL
  } eng_st_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == sel);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a quarter lasts sel+1 cycles, so ticks cannot come back to back unless sel is 0
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> !tick);
endmodule

// File: rtl/i2cm_txhold.sv
module i2cm_txhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          acc,
  output logic [DW-1:0] data,
  output logic          full
);
  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    acc    = wr && !full_q;
    full_d = full_q;
    data_d = data_q;
    if (take) full_d = 1'b0;
    if (acc) begin
      full_d = 1'b1;
      data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (acc) data_q <= data_d;
    end
  end

  assign data = data_q;
  assign full = full_q;

  // R4: the engine may only pull a byte that is really present
  a_r4_take_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full_q);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go_start,
  input  logic          stop_pend,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          sda_in,
  output logic          run,
  output logic          take,
  output logic          stop_take,
  output logic          stop_done,
  output logic          end_evt,
  output logic          ack_evt,
  output logic          ack_val,
  output logic          scl_low,
  output logic          sda_low
);
  localparam int BIT_W = $clog2(DW + 1);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DW);

  eng_st_e          st_q, st_d;
  logic [1:0]       ph_q, ph_d;
  logic [BIT_W-1:0] bn_q, bn_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             scl_q, scl_d, sda_q, sda_d;

  always_comb begin
    st_d = st_q; ph_d = ph_q; bn_d = bn_q; sh_d = sh_q;
    scl_d = scl_q; sda_d = sda_q;
    take = 1'b0; stop_take = 1'b0; stop_done = 1'b0;
    end_evt = 1'b0; ack_evt = 1'b0;
    ack_val = sda_in;
    run = (st_q != S_IDLE) && (st_q != S_HOLD);
    case (st_q)
      S_IDLE: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        if (go_start) st_d = S_SU;
      end
      S_SU:     if (tick) begin st_d = S_STA;    sda_d = 1'b1; end
      S_STA:    if (tick) begin st_d = S_STA_LO; scl_d = 1'b1; end
      S_STA_LO: if (tick) begin st_d = S_HOLD;   sda_d = 1'b0; end
      S_HOLD: begin
        if (stop_pend) begin
          stop_take = 1'b1;
          sda_d     = 1'b1;
          st_d      = S_STO_LO;
        end else if (hold_full) begin
          take = 1'b1;
          sh_d = hold_data;
          bn_d = '0;
          ph_d = 2'd0;
          st_d = S_BIT;
        end
      end
      S_BIT: begin
        if (tick) begin
          case (ph_q)
            2'd0: begin
              ph_d  = 2'd1;
              sda_d = (bn_q != LAST) ? ~sh_q[DW-1] : 1'b0;
            end
            2'd1: begin
              ph_d    = 2'd2;
              scl_d   = 1'b0;
              end_evt = (bn_q == LAST);
            end
            2'd2: begin
              ph_d    = 2'd3;
              ack_evt = (bn_q == LAST);
            end
            default: begin
              ph_d  = 2'd0;
              scl_d = 1'b1;
              if (bn_q == LAST) begin
                st_d = S_HOLD;
              end else begin
                bn_d = bn_q + 1'b1;
                sh_d = {sh_q[DW-2:0], 1'b0};
              end
            end
          endcase
        end
      end
      S_STO_LO:  if (tick) begin st_d = S_STO_HI;  scl_d = 1'b0; end
      S_STO_HI:  if (tick) begin st_d = S_STO_REL; sda_d = 1'b0; end
      S_STO_REL: if (tick) begin st_d = S_IDLE;    stop_done = 1'b1; end
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ph_q  <= 2'd0;
      bn_q  <= '0;
      sh_q  <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bn_q  <= bn_d;
      sh_q  <= sh_d;
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_low = scl_q;
  assign sda_low = sda_q;

  // R2: inside a byte SDA holds while SCL stays released
  a_r2_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BIT && !scl_q && $past(!scl_q)) |-> $stable(sda_q));
  // R8: at a byte boundary the divider is stopped, so SCL stays stretched
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HOLD) |-> !tick);
endmodule

// File: rtl/i2c_master_tx.sv
module i2c_master_tx #(
  parameter int DW    = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             mode_master,
  input  logic             mode_xmit,
  input  logic             nack_det_en,
  input  logic             ctl_wr,
  input  logic             ctl_busy_wd,
  input  logic             ctl_ss_wd,
  input  logic             dat_wr,
  input  logic [DW-1:0]    dat_wd,
  input  logic             sda_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             tx_empty,
  output logic             tx_end,
  output logic             ack_rcvd,
  output logic             nack_flag,
  output logic             bus_busy,
  output logic             stop_seen
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic          tick, run, take, stop_take, stop_done, end_evt, ack_evt, ack_val;
  logic          hold_full, dat_acc;
  logic [DW-1:0] hold_data;
  logic          start_req, stop_req;
  logic          busy_q, busy_d, pend_q, pend_d, end_q, end_d;
  logic          ack_q, ack_d, nack_q, nack_d, seen_q, seen_d;

  i2cm_qtick #(.SEL_W(SEL_W)) u_qtick (
    .clk(clk), .rst_n(rst_s), .run(run), .sel(div_sel), .tick(tick)
  );

  i2cm_txhold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_s), .wr(dat_wr), .wdata(dat_wd), .take(take),
    .acc(dat_acc), .data(hold_data), .full(hold_full)
  );

  i2cm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_s), .tick(tick), .go_start(start_req),
    .stop_pend(pend_q), .hold_full(hold_full), .hold_data(hold_data),
    .sda_in(sda_in), .run(run), .take(take), .stop_take(stop_take),
    .stop_done(stop_done), .end_evt(end_evt), .ack_evt(ack_evt),
    .ack_val(ack_val), .scl_low(scl_pull), .sda_low(sda_pull)
  );

  always_comb begin
    start_req = ctl_wr && ctl_busy_wd && !ctl_ss_wd && mode_master && mode_xmit && !busy_q;
    stop_req  = ctl_wr && !ctl_busy_wd && !ctl_ss_wd && busy_q;
    busy_d = busy_q; pend_d = pend_q; end_d = end_q;
    ack_d  = ack_q;  nack_d = nack_q; seen_d = seen_q;
    if (start_req) begin busy_d = 1'b1; seen_d = 1'b0; end
    if (stop_done) begin busy_d = 1'b0; seen_d = 1'b1; end
    if (stop_take) pend_d = 1'b0;
    if (stop_req)  pend_d = 1'b1;
    if (end_evt && !hold_full) end_d = 1'b1;
    if (dat_acc || stop_req)   end_d = 1'b0;
    if (ack_evt) ack_d = ack_val;
    if (ack_evt && ack_val && nack_det_en) nack_d = 1'b1;
    if (stop_req) nack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0; pend_q <= 1'b0; end_q  <= 1'b0;
      ack_q  <= 1'b0; nack_q <= 1'b0; seen_q <= 1'b0;
    end else begin
      busy_q <= busy_d; pend_q <= pend_d; end_q  <= end_d;
      ack_q  <= ack_d;  nack_q <= nack_d; seen_q <= seen_d;
    end
  end

  assign tx_empty  = !hold_full;
  assign tx_end    = end_q;
  assign ack_rcvd  = ack_q;
  assign nack_flag = nack_q;
  assign bus_busy  = busy_q;
  assign stop_seen = seen_q;

  // R1: an unowned bus is never clocked
  a_r1_free_bus_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !busy_q |-> !scl_pull);
  // R5: transfer end rises together with the acknowledge clock release
  a_r5_end_on_release: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(end_q) |-> (!scl_pull && $past(scl_pull)));
  // R6: a NACK indication always matches the sampled acknowledge level
  a_r6_nack_has_ack1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(nack_q) |-> ack_q);
  // R7: detection must be enabled for the flag to rise
  a_r7_nack_needs_en: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(nack_q) |-> $past(nack_det_en));
  // R9: after a completed stop both lines are free
  a_r9_stop_lines_free: assert property (@(posedge clk) disable iff (!rst_s)
    seen_q |-> (!scl_pull && !sda_pull));
endmodule

// File: tb/i2c_master_tx_tb_top.sv
`timescale 1ns/1ps
module i2c_master_tx_tb_top;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] div_sel;
  logic       mode_master, mode_xmit, nack_det_en;
  logic       ctl_wr, ctl_busy_wd, ctl_ss_wd;
  logic       dat_wr;
  logic [7:0] dat_wd;
  logic       sda_in;
  logic       scl_pull, sda_pull, tx_empty, tx_end, ack_rcvd, nack_flag, bus_busy, stop_seen;

  logic slv_pull = 1'b0;
  assign sda_in = ~(sda_pull | slv_pull);

  always #2.5 clk = ~clk;

  i2c_master_tx dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .mode_master(mode_master),
    .mode_xmit(mode_xmit), .nack_det_en(nack_det_en), .ctl_wr(ctl_wr),
    .ctl_busy_wd(ctl_busy_wd), .ctl_ss_wd(ctl_ss_wd), .dat_wr(dat_wr),
    .dat_wd(dat_wd), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .tx_empty(tx_empty), .tx_end(tx_end), .ack_rcvd(ack_rcvd),
    .nack_flag(nack_flag), .bus_busy(bus_busy), .stop_seen(stop_seen)
  );

  int errs = 0, chks = 0, cyc = 0;
  int cur_q = 1;

  // Slave-side monitor state
  logic       prev_scl = 1'b1, prev_sda = 1'b1, mon_on = 1'b0;
  int         starts = 0, stops = 0, bitcnt = 0, rx_n = 0;
  int         rise_cyc = 0, fall_cyc = 0, per_bad = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] rx_bytes [0:63];
  logic       nack_plan [0:63];
  logic       end_at_rise [0:63];

  function automatic int q_len(input logic [3:0] s);
    return int'(s) + 1;
  endfunction

  function automatic logic exp_nack(input logic en, input logic any_nack);
    return en & any_nack;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, chks);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      chks++; errs++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = ~scl_pull;
    sda_l = ~(sda_pull | slv_pull);
    if (mon_on) begin
      if (prev_scl && scl_l && prev_sda && !sda_l) begin starts++; bitcnt = 0; end
      else if (prev_scl && scl_l && !prev_sda && sda_l) stops++;
      if (!prev_scl && scl_l) begin
        if (bitcnt >= 1 && bitcnt <= 8 && (cyc - fall_cyc) != 2*cur_q) per_bad++;
        rise_cyc = cyc;
        if (bitcnt < 8) rx_sh = {rx_sh[6:0], sda_l};
        else if (bitcnt == 8) end_at_rise[rx_n] = tx_end;
        bitcnt++;
      end
      if (prev_scl && !scl_l) begin
        if (bitcnt >= 1 && bitcnt <= 9 && (cyc - rise_cyc) != 2*cur_q) per_bad++;
        fall_cyc = cyc;
        if (bitcnt == 8) slv_pull = !nack_plan[rx_n];
        if (bitcnt == 9) begin
          slv_pull = 1'b0;
          rx_bytes[rx_n] = rx_sh;
          rx_n++;
          bitcnt = 0;
        end
      end
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl_write(input logic b, input logic s);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_busy_wd = b; ctl_ss_wd = s;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] d);
    @(negedge clk);
    dat_wr = 1'b1; dat_wd = d;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    int t = 0;
    while (rx_n < n && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_empty();
    int t = 0;
    while (!tx_empty && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_end();
    int t = 0;
    while (!tx_end && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_stop();
    int t = 0;
    while (!stop_seen && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic set_div(input logic [3:0] s);
    div_sel = s;
    cur_q   = q_len(s);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin nack_plan[i] = 1'b0; end_at_rise[i] = 1'b0; end
    rst_n = 1'b0; set_div(4'd1);
    mode_master = 1'b0; mode_xmit = 1'b0; nack_det_en = 1'b0;
    ctl_wr = 1'b0; ctl_busy_wd = 1'b0; ctl_ss_wd = 1'b0;
    dat_wr = 1'b0; dat_wd = '0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    mon_on = 1'b1;

    // Reset state
    chk("R4 reset tx_empty", tx_empty, 1);
    chk("R5 reset tx_end", tx_end, 0);
    chk("R6 reset ack_rcvd", ack_rcvd, 0);
    chk("R7 reset nack_flag", nack_flag, 0);
    chk("R1 reset bus_busy", bus_busy, 0);
    chk("R9 reset lines", {scl_pull, sda_pull}, 0);

    // R1: start refused without master mode, and with control bit 1
    mode_xmit = 1'b1;
    ctl_write(1'b1, 1'b0);
    idle(40);
    chk("R1 no start without master mode", bus_busy + starts, 0);
    mode_master = 1'b1;
    ctl_write(1'b1, 1'b1);
    idle(40);
    chk("R1 no start with control bit set", bus_busy + starts, 0);

    // Directed transfer, divider 1
    ctl_write(1'b1, 1'b0);
    chk("R1 busy after start", bus_busy, 1);
    idle(30);
    chk("R1 start condition seen", starts, 1);
    chk("R8 SCL stretched before data", {scl_pull, sda_pull, tx_end}, 3'b100);
    data_write(8'hA4);
    chk("R4 write clears tx_empty", tx_empty, 0);
    idle(2);
    chk("R4 transfer sets tx_empty", tx_empty, 1);
    data_write(8'h3C);
    chk("R4 queued byte", tx_empty, 0);
    data_write(8'hFF);
    wait_rx(2);
    idle(20);
    chk("R2 byte 0", rx_bytes[0], 8'hA4);
    chk("R4 byte 1 not overwritten", rx_bytes[1], 8'h3C);
    chk("R5 tx_end after last byte", tx_end, 1);
    chk("R5 no end while queued", end_at_rise[0], 0);
    chk("R5 end at ack clock", end_at_rise[1], 1);
    chk("R6 ack received", ack_rcvd, 0);
    chk("R8 SCL stretched between bytes", {scl_pull, sda_pull}, 2'b10);
    chk("R3 phase lengths div 1", per_bad, 0);
    idle(200);
    chk("R4 ignored write not sent", rx_n, 2);
    data_write(8'h81);
    chk("R5 data write clears tx_end", tx_end, 0);
    nack_det_en = 1'b1;
    nack_plan[3] = 1'b1;
    wait_empty();
    data_write(8'h5A);
    wait_rx(4);
    idle(10);
    chk("R2 byte 2", rx_bytes[2], 8'h81);
    chk("R2 byte 3", rx_bytes[3], 8'h5A);
    chk("R6 NACK sampled", ack_rcvd, 1);
    chk("R7 nack flag set", nack_flag, 1);
    chk("R5 tx_end before stop", tx_end, 1);
    ctl_write(1'b0, 1'b0);
    chk("R5 stop clears tx_end", tx_end, 0);
    chk("R7 stop clears nack", nack_flag, 0);
    wait_stop();
    idle(2);
    chk("R9 stop seen", stop_seen, 1);
    chk("R9 stop condition on bus", stops, 1);
    chk("R9 bus released", {bus_busy, scl_pull, sda_pull}, 0);

    // NACK with detection off, divider 0
    set_div(4'd0);
    nack_det_en = 1'b0;
    ctl_write(1'b1, 1'b0);
    chk("R1 start clears stop_seen", stop_seen, 0);
    nack_plan[4] = 1'b1;
    data_write(8'hC3);
    wait_rx(5);
    idle(10);
    chk("R2 byte 4", rx_bytes[4], 8'hC3);
    chk("R6 NACK sampled div 0", ack_rcvd, 1);
    chk("R7 no flag when disabled", nack_flag, 0);
    chk("R3 phase lengths div 0", per_bad, 0);
    ctl_write(1'b0, 1'b0);
    wait_stop();
    chk("R9 second stop", stops, 2);

    // Random transactions
    void'($urandom(32'd2024));
    for (int t = 0; t < 6; t++) begin
      int   nb, base;
      logic en, anyn;
      logic [7:0] bytes [0:3];
      set_div(4'($urandom_range(15, 0)));
      en = 1'($urandom_range(1, 0));
      nack_det_en = en;
      nb = $urandom_range(4, 1);
      base = rx_n;
      anyn = 1'b0;
      for (int k = 0; k < nb; k++) begin
        bytes[k] = 8'($urandom_range(255, 0));
        nack_plan[base+k] = ($urandom_range(3, 0) == 0);
        anyn |= nack_plan[base+k];
      end
      ctl_write(1'b1, 1'b0);
      for (int k = 0; k < nb; k++) begin
        wait_empty();
        data_write(bytes[k]);
      end
      wait_end();
      wait_rx(base + nb);
      idle(5);
      for (int k = 0; k < nb; k++) chk("R2 random byte", rx_bytes[base+k], bytes[k]);
      chk("R5 random end at ack clock", end_at_rise[base+nb-1], 1);
      chk("R6 random ack", ack_rcvd, nack_plan[base+nb-1]);
      chk("R7 random nack flag", nack_flag, exp_nack(en, anyn));
      chk("R3 random phase lengths", per_bad, 0);
      ctl_write(1'b0, 1'b0);
      wait_stop();
      chk("R9 random stop", stops, 3 + t);
    end

    summary();
    $finish;
  end
endmodule